// File: doc/BRIEF.md
# Out-of-Order Issue Window

This block sits between instruction decode and the execution units. Decode writes up to two decoded instructions per cycle into free window slots. Each instruction carries a functional-unit class, two source operand tags with ready flags, and a destination tag. Inside the window an instruction waits until both of its sources are ready and a unit of its class is free. It is then sent to that unit, whether or not older instructions are still waiting.

Result broadcasts from the execution side carry destination tags. Every stored source operand whose tag matches a broadcast becomes ready. Where several ready instructions compete for one unit, the oldest of them wins; age is kept as a per-entry ordering matrix. A slot is released on the clock edge that ends its issue cycle. That slot already counts as free during that cycle, so decode can refill it at once. When the window has no room, decode sees it through a two-bit space signal.

Top module: `issue_window`

## Requirements
- R1: After reset the window is empty: no `iss_valid` bit is set and `in_space` is 2'b11.
- R2: Bit 0 of `in_space` means at least one slot is free; bit 1 means at least two are free. A slot counts as free if it is empty or issuing in the current cycle. Decode slot k is stored only when both `in_valid[k]` and `in_space[k]` are set; a write without space is dropped and never issues.
- R3: The window holds ENTRIES instructions (12 by default). When every slot is occupied and none is issuing, `in_space` is 2'b00.
- R4: `iss_valid[f]` rises only while `fu_free[f]` is 1. It selects a stored entry of class f whose two sources are both ready. A stored entry can issue in the cycle after the one in which it was written.
- R5: A younger entry that is ready issues ahead of an older entry of the same class that still waits on an operand.
- R6: Among ready entries of one class, the one written earliest issues first. Slot 0 counts as older than slot 1 within one write cycle.
- R7: When `wb_valid[k]` is set, every stored source whose tag equals broadcast k's tag becomes ready at the next edge. Both broadcast ports act in the same cycle. The woken entry can issue in the following cycle.
- R8: If an incoming source tag matches a broadcast in the cycle it is written, that source is stored as ready.
- R9: An issued entry is released at the end of its issue cycle. In that same cycle it counts toward `in_space`, so a new instruction can reuse it.
- R10: Different units issue independently in the same cycle, each with its own selected entry.
- R11: Class value f addresses unit f, for f from 0 to NUM_FU-1. Decode slot k occupies bits [k*W +: W] of each packed input field. Unit f's outputs occupy bits [f*TAG_W +: TAG_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Write request per decode slot |
| in_cls | input | 2*CLS_W | Unit class per slot |
| in_sa | input | 2*TAG_W | Source A tag per slot |
| in_sa_rdy | input | 2 | Source A already ready per slot |
| in_sb | input | 2*TAG_W | Source B tag per slot |
| in_sb_rdy | input | 2 | Source B already ready per slot |
| in_dst | input | 2*TAG_W | Destination tag per slot |
| in_space | output | 2 | Room for one / two writes this cycle |
| wb_valid | input | WB_N | Result broadcast valid per port |
| wb_tag | input | WB_N*TAG_W | Broadcast tags |
| fu_free | input | NUM_FU | Unit can accept an instruction this cycle |
| iss_valid | output | NUM_FU | Issue per unit |
| iss_dst | output | NUM_FU*TAG_W | Destination tag of issued entry per unit |
| iss_sa | output | NUM_FU*TAG_W | Source A tag of issued entry per unit |
| iss_sb | output | NUM_FU*TAG_W | Source B tag of issued entry per unit |

## Verification
Two pairs of events can fall in one cycle. The first pair is an issue and a write into the slot that issue frees. The bench fills the window with every unit busy, then frees one unit while it writes. It expects `in_space` of 2'b01 and then a complete drain in age order, with the refilled entry last. The second pair is a broadcast and a write whose source carries the broadcast tag. The bench expects that entry to issue as soon as its other operand is woken, with no second broadcast of the first tag.

// File: rtl/issue_window.sv
module issue_window #(
  parameter int ENTRIES = 12,
  parameter int TAG_W   = 6,
  parameter int NUM_FU  = 3,
  parameter int WB_N    = 2,
  localparam int CLS_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              in_valid,
  input  logic [2*CLS_W-1:0]      in_cls,
  input  logic [2*TAG_W-1:0]      in_sa,
  input  logic [1:0]              in_sa_rdy,
  input  logic [2*TAG_W-1:0]      in_sb,
  input  logic [1:0]              in_sb_rdy,
  input  logic [2*TAG_W-1:0]      in_dst,
  output logic [1:0]              in_space,
  input  logic [WB_N-1:0]         wb_valid,
  input  logic [WB_N*TAG_W-1:0]   wb_tag,
  input  logic [NUM_FU-1:0]       fu_free,
  output logic [NUM_FU-1:0]       iss_valid,
  output logic [NUM_FU*TAG_W-1:0] iss_dst,
  output logic [NUM_FU*TAG_W-1:0] iss_sa,
  output logic [NUM_FU*TAG_W-1:0] iss_sb
);

  logic [ENTRIES-1:0] vld, ra, rb;
  logic [CLS_W-1:0]   cls [ENTRIES];
  logic [TAG_W-1:0]   ta  [ENTRIES];
  logic [TAG_W-1:0]   tb  [ENTRIES];
  logic [TAG_W-1:0]   td  [ENTRIES];
  logic [ENTRIES-1:0] older [ENTRIES];

  logic [ENTRIES-1:0] req [NUM_FU];
  logic [ENTRIES-1:0] gnt [NUM_FU];
  logic [ENTRIES-1:0] gnt_any, avail, wr_e, hit_a, hit_b;
  logic [1:0]         nhit_a, nhit_b;
  logic [IDX_W-1:0]   idx0, idx1;
  logic               have0, have1, wr0, wr1;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      hit_a[e] = 1'b0;
      hit_b[e] = 1'b0;
      for (int k = 0; k < WB_N; k++) begin
        if (wb_valid[k] && wb_tag[k*TAG_W +: TAG_W] == ta[e]) hit_a[e] = 1'b1;
        if (wb_valid[k] && wb_tag[k*TAG_W +: TAG_W] == tb[e]) hit_b[e] = 1'b1;
      end
    end
    for (int s = 0; s < 2; s++) begin
      nhit_a[s] = 1'b0;
      nhit_b[s] = 1'b0;
      for (int k = 0; k < WB_N; k++) begin
        if (wb_valid[k] && wb_tag[k*TAG_W +: TAG_W] == in_sa[s*TAG_W +: TAG_W]) nhit_a[s] = 1'b1;
        if (wb_valid[k] && wb_tag[k*TAG_W +: TAG_W] == in_sb[s*TAG_W +: TAG_W]) nhit_b[s] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int f = 0; f < NUM_FU; f++) begin
      for (int e = 0; e < ENTRIES; e++)
        req[f][e] = vld[e] && ra[e] && rb[e] && fu_free[f] && (cls[e] == CLS_W'(f));
      for (int e = 0; e < ENTRIES; e++) begin
        gnt[f][e] = req[f][e];
        for (int j = 0; j < ENTRIES; j++)
          if (j != e && req[f][j] && older[j][e]) gnt[f][e] = 1'b0;
      end
    end
  end

  always_comb begin
    gnt_any   = '0;
    iss_valid = '0;
    iss_dst   = '0;
    iss_sa    = '0;
    iss_sb    = '0;
    for (int f = 0; f < NUM_FU; f++) begin
      gnt_any      = gnt_any | gnt[f];
      iss_valid[f] = |gnt[f];
      for (int e = 0; e < ENTRIES; e++)
        if (gnt[f][e]) begin
          iss_dst[f*TAG_W +: TAG_W] = iss_dst[f*TAG_W +: TAG_W] | td[e];
          iss_sa[f*TAG_W +: TAG_W]  = iss_sa[f*TAG_W +: TAG_W]  | ta[e];
          iss_sb[f*TAG_W +: TAG_W]  = iss_sb[f*TAG_W +: TAG_W]  | tb[e];
        end
    end
  end

  assign avail = ~vld | gnt_any;

  always_comb begin
    have0 = 1'b0;
    have1 = 1'b0;
    idx0  = '0;
    idx1  = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (avail[e]) begin
        if (!have0) begin
          have0 = 1'b1;
          idx0  = IDX_W'(e);
        end else if (!have1) begin
          have1 = 1'b1;
          idx1  = IDX_W'(e);
        end
      end
  end

  assign in_space = {have1, have0};
  assign wr0 = in_valid[0] && have0;
  assign wr1 = in_valid[1] && have1;

  always_comb
    for (int e = 0; e < ENTRIES; e++)
      wr_e[e] = (wr0 && idx0 == IDX_W'(e)) || (wr1 && idx1 == IDX_W'(e));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      ra  <= '0;
      rb  <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (gnt_any[e]) vld[e] <= 1'b0;
        if (hit_a[e])   ra[e]  <= 1'b1;
        if (hit_b[e])   rb[e]  <= 1'b1;
      end
      if (wr0) begin
        vld[idx0] <= 1'b1;
        ra[idx0]  <= in_sa_rdy[0] | nhit_a[0];
        rb[idx0]  <= in_sb_rdy[0] | nhit_b[0];
      end
      if (wr1) begin
        vld[idx1] <= 1'b1;
        ra[idx1]  <= in_sa_rdy[1] | nhit_a[1];
        rb[idx1]  <= in_sb_rdy[1] | nhit_b[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr0) begin
      cls[idx0] <= in_cls[0 +: CLS_W];
      ta[idx0]  <= in_sa[0 +: TAG_W];
      tb[idx0]  <= in_sb[0 +: TAG_W];
      td[idx0]  <= in_dst[0 +: TAG_W];
      for (int j = 0; j < ENTRIES; j++) begin
        older[idx0][j] <= 1'b0;
        older[j][idx0] <= 1'b1;
      end
    end
    if (wr1) begin
      cls[idx1] <= in_cls[CLS_W +: CLS_W];
      ta[idx1]  <= in_sa[TAG_W +: TAG_W];
      tb[idx1]  <= in_sb[TAG_W +: TAG_W];
      td[idx1]  <= in_dst[TAG_W +: TAG_W];
      for (int j = 0; j < ENTRIES; j++) begin
        older[idx1][j] <= 1'b0;
        older[j][idx1] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/issue_window_chk.sv
module issue_window_chk #(
  parameter int ENTRIES = 12,
  parameter int NUM_FU  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_FU-1:0]  fu_free,
  input logic [NUM_FU-1:0]  iss_valid,
  input logic [1:0]         in_space,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] ra,
  input logic [ENTRIES-1:0] rb,
  input logic [ENTRIES-1:0] gnt_any,
  input logic [ENTRIES-1:0] wr_e,
  input logic [ENTRIES-1:0] hit_a,
  input logic [ENTRIES-1:0] hit_b
);

  AST_SPACE_NESTED: assert property (@(posedge clk) disable iff (!rst_n) in_space[1] |-> in_space[0]); // R2
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n) ((&vld) && iss_valid == '0) |-> in_space == 2'b00); // R3
  AST_ISSUE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $countones(iss_valid) <= $countones(vld)); // R10

  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    AST_BUSY_UNIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) iss_valid[f] |-> fu_free[f]); // R4
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n) gnt_any[e] |-> (vld[e] && ra[e] && rb[e])); // R4
    AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (!rst_n) (gnt_any[e] && !wr_e[e]) |=> !vld[e]); // R9
    AST_WAKE_A: assert property (@(posedge clk) disable iff (!rst_n) (vld[e] && !gnt_any[e] && hit_a[e]) |=> ra[e]); // R7
    AST_WAKE_B: assert property (@(posedge clk) disable iff (!rst_n) (vld[e] && !gnt_any[e] && hit_b[e]) |=> rb[e]); // R7
  end

endmodule

bind issue_window issue_window_chk #(.ENTRIES(ENTRIES), .NUM_FU(NUM_FU)) u_chk (
  .clk(clk), .rst_n(rst_n), .fu_free(fu_free), .iss_valid(iss_valid), .in_space(in_space),
  .vld(vld), .ra(ra), .rb(rb), .gnt_any(gnt_any), .wr_e(wr_e), .hit_a(hit_a), .hit_b(hit_b)
);

// File: tb/issue_window_bench.sv
module issue_window_bench;
  localparam int T = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  in_valid = '0;
  logic [3:0]  in_cls = '0;
  logic [11:0] in_sa = '0, in_sb = '0, in_dst = '0;
  logic [1:0]  in_sa_rdy = '0, in_sb_rdy = '0;
  logic [1:0]  in_space;
  logic [1:0]  wb_valid = '0;
  logic [11:0] wb_tag = '0;
  logic [2:0]  fu_free = '0;
  logic [2:0]  iss_valid;
  logic [17:0] iss_dst, iss_sa, iss_sb;

  int total = 0;
  int bad = 0;

  always #(T/2) clk = ~clk;

  issue_window u_issue_window (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_sa(in_sa), .in_sa_rdy(in_sa_rdy), .in_sb(in_sb), .in_sb_rdy(in_sb_rdy),
    .in_dst(in_dst), .in_space(in_space), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .fu_free(fu_free), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_sa(iss_sa), .iss_sb(iss_sb)
  );

  typedef struct packed {
    logic [1:0] v;
    logic [1:0] c0; logic [5:0] a0; logic ar0; logic [5:0] b0; logic br0; logic [5:0] d0;
    logic [1:0] c1; logic [5:0] a1; logic ar1; logic [5:0] b1; logic br1; logic [5:0] d1;
    logic       wv; logic [5:0] wt;
    logic [2:0] fr; logic [2:0] ev;
    logic [5:0] e0; logic [5:0] e1; logic [5:0] e2;
    logic [1:0] sp; logic [3:0] rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{3, 0,1,1,2,1,10,   0,10,0,2,1,11,  0,0,  7, 0, 0,0,0,  3, 2},  // R2 pair write
    '{3, 1,11,0,3,1,12,  0,4,1,5,1,13,   0,0,  7, 1, 10,0,0, 3, 4},  // R4
    '{0, 0,0,0,0,0,0,    0,0,0,0,0,0,    1,10, 7, 1, 13,0,0, 3, 5},  // R5 bypass
    '{0, 0,0,0,0,0,0,    0,0,0,0,0,0,    1,11, 7, 1, 11,0,0, 3, 7},  // R7
    '{0, 0,0,0,0,0,0,    0,0,0,0,0,0,    0,0,  7, 2, 0,12,0, 3, 7},  // R7 R11
    '{3, 2,1,1,2,1,20,   2,1,1,2,1,21,   0,0,  7, 0, 0,0,0,  3, 2},
    '{1, 2,1,1,2,1,22,   0,0,0,0,0,0,    0,0,  3, 0, 0,0,0,  3, 4},  // R4 unit busy
    '{0, 0,0,0,0,0,0,    0,0,0,0,0,0,    0,0,  7, 4, 0,0,20, 3, 6},  // R6
    '{0, 0,0,0,0,0,0,    0,0,0,0,0,0,    0,0,  7, 4, 0,0,21, 3, 6},  // R6
    '{0, 0,0,0,0,0,0,    0,0,0,0,0,0,    0,0,  7, 4, 0,0,22, 3, 6},  // R6
    '{3, 0,1,1,2,1,30,   1,1,1,2,1,31,   0,0,  7, 0, 0,0,0,  3, 10},
    '{0, 0,0,0,0,0,0,    0,0,0,0,0,0,    0,0,  7, 3, 30,31,0, 3, 10}, // R10
    '{1, 0,40,0,41,0,42, 0,0,0,0,0,0,    1,40, 7, 0, 0,0,0,  3, 8},  // R8
    '{0, 0,0,0,0,0,0,    0,0,0,0,0,0,    1,41, 7, 0, 0,0,0,  3, 8},
    '{0, 0,0,0,0,0,0,    0,0,0,0,0,0,    0,0,  7, 1, 42,0,0, 3, 8}   // R8
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = '0; in_cls = '0; in_sa = '0; in_sb = '0; in_dst = '0;
    in_sa_rdy = '0; in_sb_rdy = '0; wb_valid = '0; wb_tag = '0;
  endtask

  task automatic set_slot(input int k, input logic [1:0] c, input logic [5:0] a, input logic ar,
                          input logic [5:0] b, input logic br, input logic [5:0] d);
    in_cls[k*2 +: 2] = c;
    in_sa[k*6 +: 6]  = a;  in_sa_rdy[k] = ar;
    in_sb[k*6 +: 6]  = b;  in_sb_rdy[k] = br;
    in_dst[k*6 +: 6] = d;
  endtask

  initial begin
    #(T*100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 iss_valid", iss_valid, 0);
    check("R1 in_space", in_space, 3);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clear_in();
      in_valid = TBL[i].v;
      set_slot(0, TBL[i].c0, TBL[i].a0, TBL[i].ar0, TBL[i].b0, TBL[i].br0, TBL[i].d0);
      set_slot(1, TBL[i].c1, TBL[i].a1, TBL[i].ar1, TBL[i].b1, TBL[i].br1, TBL[i].d1);
      wb_valid = {1'b0, TBL[i].wv};
      wb_tag[5:0] = TBL[i].wt;
      fu_free = TBL[i].fr;
      #1;
      check($sformatf("R%0d row%0d iss_valid", TBL[i].rq, i), iss_valid, TBL[i].ev);
      check($sformatf("R%0d row%0d in_space", TBL[i].rq, i), in_space, TBL[i].sp);
      if (TBL[i].ev[0]) check($sformatf("R%0d row%0d dst0", TBL[i].rq, i), iss_dst[5:0], TBL[i].e0);
      if (TBL[i].ev[1]) check($sformatf("R%0d row%0d dst1", TBL[i].rq, i), iss_dst[11:6], TBL[i].e1);
      if (TBL[i].ev[2]) check($sformatf("R%0d row%0d dst2", TBL[i].rq, i), iss_dst[17:12], TBL[i].e2);
    end

    // R3 fill with all units busy
    for (int p = 0; p < 5; p++) begin
      @(negedge clk);
      clear_in();
      fu_free = 3'b000;
      in_valid = 2'b11;
      set_slot(0, 0, 1, 1, 2, 1, 6'(50 + 2*p));
      set_slot(1, 0, 1, 1, 2, 1, 6'(51 + 2*p));
      #1;
      check("R2 space while filling", in_space, 3);
    end
    @(negedge clk);
    clear_in();
    in_valid = 2'b01;
    set_slot(0, 0, 1, 1, 2, 1, 60);
    #1;
    check("R2 space with ten held", in_space, 3);
    @(negedge clk);
    clear_in();
    in_valid = 2'b11;
    set_slot(0, 0, 1, 1, 2, 1, 61);
    set_slot(1, 0, 1, 1, 2, 1, 62);
    #1;
    check("R2 space with eleven held", in_space, 1);
    @(negedge clk);
    clear_in();
    in_valid = 2'b01;
    set_slot(0, 0, 1, 1, 2, 1, 63);
    #1;
    check("R3 space when full", in_space, 0);
    check("R3 no issue when units busy", iss_valid, 0);

    // R9 issue and refill in one cycle
    @(negedge clk);
    clear_in();
    fu_free = 3'b001;
    in_valid = 2'b01;
    set_slot(0, 0, 1, 1, 2, 1, 45);
    #1;
    check("R9 issue while full", iss_valid, 1);
    check("R6 oldest first", iss_dst[5:0], 50);
    check("R9 space from issuing slot", in_space, 1);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      clear_in();
      fu_free = 3'b001;
      #1;
      check("R6 drain valid", iss_valid, 1);
      check("R6 drain order", iss_dst[5:0], (n < 11) ? 32'(51 + n) : 32'd45);
    end
    @(negedge clk);
    clear_in();
    fu_free = 3'b111;
    #1;
    check("R2 dropped writes never issue", iss_valid, 0);

    // R7 both broadcast ports
    @(negedge clk);
    clear_in();
    in_valid = 2'b01;
    set_slot(0, 1, 7, 0, 8, 0, 33);
    @(negedge clk);
    clear_in();
    wb_valid = 2'b11;
    wb_tag = {6'd8, 6'd7};
    #1;
    check("R7 waiting before wakeup", iss_valid, 0);
    @(negedge clk);
    clear_in();
    #1;
    check("R7 issue after two-port wakeup", iss_valid, 3'b010);
    check("R11 unit1 dst field", iss_dst[11:6], 33);
    check("R11 unit1 source a field", iss_sa[11:6], 7);
    check("R11 unit1 source b field", iss_sb[11:6], 8);

    // R1 reset clears pending entries
    @(negedge clk);
    clear_in();
    fu_free = 3'b000;
    in_valid = 2'b01;
    set_slot(0, 0, 1, 1, 2, 1, 5);
    @(negedge clk);
    clear_in();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    fu_free = 3'b111;
    #1;
    check("R1 reset empties window", iss_valid, 0);
    check("R1 reset space", in_space, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule